// File: doc/BRIEF.md
# Keyed-Write Watchdog Timer

This block is a watchdog timer peripheral. It holds an 8-bit up-counter and an 8-bit control/status register, and a simple 16-bit register bus reaches both. A write takes effect only when it is 16 bits wide and its upper byte carries the key for the register it targets. Any other write leaves the block untouched, which guards both registers against stray software stores. A read returns the 8-bit register value.

A prescaler divides the system clock by a power of two between 32 and 4096, and a 3-bit code in the control/status register picks the ratio. Each prescaler tick advances the counter by one. When the counter wraps from 0xFF to 0x00, the block sets an overflow flag. In watchdog mode, the wrap also drives an active-high reset output for 16 system clocks. In interval mode, software polls the flag and clears it with a keyed write. Software services the watchdog by writing the counter back to a low value before it wraps.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, the counter reads 0x00, the control/status register reads 0x00 (clock code 0, ratio 1/32) and `wdt_rst` is low.
- R2: A 16-bit write to the counter (`bus_sel`=0) whose bits 15:8 equal 0x5A loads bits 7:0 into the counter at that clock edge. A load takes priority over a tick in the same cycle.
- R3: A 16-bit write to the control/status register (`bus_sel`=1) whose bits 15:8 equal 0xA5 updates that register. Bit 7 enables counting, bit 6 selects watchdog mode (1) or interval mode (0), bit 5 is the overflow flag, and bits 2:0 are the clock code. Bits 4:3 always read 0.
- R4: A write with a wrong key, or any write with `bus_wide`=0, changes neither register.
- R5: `bus_rdata` combinationally returns the 8-bit value of the register that `bus_sel` selects.
- R6: While counting is enabled, the counter advances once every 32·2^code clocks. The first advance comes 32·2^code clocks after the edge of the enabling write. While counting is disabled, the counter holds.
- R7: The prescaler restarts from zero when counting is disabled, and at a keyed control write that changes the clock code. The next advance then comes a full period after that write.
- R8: When the counter wraps from 0xFF to 0x00, the overflow flag sets at that edge. A keyed control write with bit 5 = 0 clears the flag. Writing 1 to bit 5 never sets it, and a wrap in the same cycle wins over a clear.
- R9: In watchdog mode, a wrap raises `wdt_rst` at the same edge and holds it high for exactly 16 clocks. In interval mode, a wrap leaves `wdt_rst` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register select: 0 counter, 1 control/status |
| bus_we | input | 1 | Write strobe, one cycle |
| bus_wide | input | 1 | High for a 16-bit access, low for a byte access |
| bus_wdata | input | 16 | Write data: key in 15:8, value in 7:0 |
| bus_rdata | output | 8 | Read data of the selected register |
| wdt_rst | output | 1 | Watchdog reset pulse, active high |

## Verification
The bench measures the first counter advance to the exact cycle, both just before and just after the expected edge. A prescaler that starts one count late, or keeps its count across a code change or a disable, shows up as a counter off by one in one of those two samples. It preloads 0xFF to reach a wrap quickly at the slowest and the fastest ratios. At each wrap it checks the flag, the counter and the reset pulse edges, so a pulse of 15 or 17 clocks, or a pulse in interval mode, is reported. It also sends swapped keys, near-miss keys and byte-wide writes, and expects no change. A design that checks only part of the key, or ignores the access width, would let one of these writes through.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W    = 16;
  localparam int REG_W     = 8;
  localparam int KEY_W     = DATA_W - REG_W;
  localparam logic [KEY_W-1:0] KEY_COUNT = 8'h5A;
  localparam logic [KEY_W-1:0] KEY_CTRL  = 8'hA5;
  // control/status bit positions
  localparam int BIT_EN    = 7;
  localparam int BIT_WD    = 6;
  localparam int BIT_FLAG  = 5;
  localparam int SEL_W     = 3;
  localparam int BASE_LOG2 = 5;
  localparam int PRE_W     = BASE_LOG2 + (1 << SEL_W) - 1;
  localparam int RST_LEN   = 16;

  typedef enum logic {REG_COUNT = 1'b0, REG_CTRL = 1'b1} reg_sel_e;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int SEL_W     = wdt_pkg::SEL_W,
  parameter int BASE_LOG2 = wdt_pkg::BASE_LOG2,
  localparam int PRE_W    = BASE_LOG2 + (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [SEL_W-1:0] code,
  output logic             tick
);
  logic [PRE_W-1:0] cnt_q, cnt_d;
  logic [PRE_W:0]   span;
  logic [PRE_W-1:0] last;

  always_comb begin
    span = ({{PRE_W{1'b0}}, 1'b1} << (BASE_LOG2 + int'(code))) - 1'b1;
    last = span[PRE_W-1:0];
    tick = run && !restart && (cnt_q == last);
    if (!run || restart || tick) cnt_d = '0;
    else                         cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R6: the shortest ratio is 32, so ticks never come back to back
  a_r6_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  // R7: no tick in the cycle after a restart
  a_r7_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = wdt_pkg::REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic [CNT_W-1:0] value,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    wrap   = tick && !load && (cnt_q == {CNT_W{1'b1}});
    cnt_en = load || tick;
    cnt_d  = load ? load_val : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign value = cnt_q;

  // R4: without a keyed load or a tick the count never moves
  a_r4_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(value));
  // R8: a wrap always leaves the counter at zero
  a_r8_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (value == '0));
endmodule

// File: rtl/wdt_rst_pulse.sv
module wdt_rst_pulse #(
  parameter int LEN = wdt_pkg::RST_LEN,
  localparam int CW = $clog2(LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse
);
  logic [CW-1:0] left_q, left_d;

  always_comb begin
    if (fire)               left_d = CW'(LEN);
    else if (left_q != '0)  left_d = left_q - 1'b1;
    else                    left_d = left_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end

  assign pulse = (left_q != '0);

  // R9: a fire raises the output at the next edge
  a_r9_pulse_start: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> pulse);
  // R9: the output only rises because of a fire
  a_r9_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse) |-> $past(fire));
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic              bus_wide,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              wdt_rst
);
  logic             en_q, wd_q, flag_q;
  logic [SEL_W-1:0] code_q;
  logic             en_d, wd_d, flag_d;
  logic [SEL_W-1:0] code_d;
  logic             cnt_we, ctrl_we, code_chg;
  logic [KEY_W-1:0] key;
  logic [REG_W-1:0] wval, count, ctrl;
  logic             tick, wrap;

  assign key  = bus_wdata[DATA_W-1:REG_W];
  assign wval = bus_wdata[REG_W-1:0];

  // key check
  always_comb begin
    cnt_we   = bus_we && bus_wide && (bus_sel == REG_COUNT) && (key == KEY_COUNT);
    ctrl_we  = bus_we && bus_wide && (bus_sel == REG_CTRL)  && (key == KEY_CTRL);
    code_chg = ctrl_we && (wval[SEL_W-1:0] != code_q);
  end

  // control/status next state
  always_comb begin
    en_d   = ctrl_we ? wval[BIT_EN] : en_q;
    wd_d   = ctrl_we ? wval[BIT_WD] : wd_q;
    code_d = ctrl_we ? wval[SEL_W-1:0] : code_q;
    flag_d = (ctrl_we ? (flag_q && wval[BIT_FLAG]) : flag_q) || wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      wd_q   <= 1'b0;
      code_q <= '0;
      flag_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      wd_q   <= wd_d;
      code_q <= code_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    ctrl = '0;
    ctrl[BIT_EN]      = en_q;
    ctrl[BIT_WD]      = wd_q;
    ctrl[BIT_FLAG]    = flag_q;
    ctrl[SEL_W-1:0]   = code_q;
    bus_rdata = (bus_sel == REG_CTRL) ? ctrl : count;
  end

  wdt_prescaler #(.SEL_W(SEL_W), .BASE_LOG2(BASE_LOG2)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(en_q), .restart(code_chg),
    .code(code_q), .tick(tick));

  wdt_counter #(.CNT_W(REG_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_we), .load_val(wval),
    .tick(tick), .value(count), .wrap(wrap));

  wdt_rst_pulse #(.LEN(RST_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(wrap && wd_q), .pulse(wdt_rst));

  // R8: a wrap sets the flag at the same edge
  a_r8_flag_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flag_q);
  // R3: control fields move only on a keyed control write
  a_r3_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_we |=> $stable({en_q, wd_q, code_q}));
  // R9: no reset pulse begins in interval mode
  a_r9_interval_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!wdt_rst && !(wrap && wd_q)) |=> !wdt_rst);
endmodule

// File: tb/test_keyed_wdt.sv
module test_keyed_wdt;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_we, bus_wide;
  logic [15:0] bus_wdata;
  logic [7:0]  bus_rdata;
  logic        wdt_rst;
  int          n_chk = 0, n_bad = 0;
  int          cyc = 0;

  always #4 clk = ~clk;  // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;

  keyed_wdt i_keyed_wdt (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_wide(bus_wide), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_rst(wdt_rst));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic s, output logic [7:0] v);
    bus_sel = s;
    #1;
    v = bus_rdata;
  endtask

  // at a negedge: drive, take the edge, return at the following negedge
  task automatic wr(input logic s, input logic [15:0] d, input logic wide = 1'b1);
    bus_sel = s; bus_wdata = d; bus_we = 1'b1; bus_wide = wide;
    @(negedge clk);
    bus_we = 1'b0; bus_wide = 1'b1;
  endtask

  task automatic skip(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_cnt(input string tag, input int exp);
    logic [7:0] v;
    rd(1'b0, v);
    chk(tag, v, exp);
  endtask

  task automatic chk_ctrl(input string tag, input int exp);
    logic [7:0] v;
    rd(1'b1, v);
    chk(tag, v, exp);
  endtask

  task automatic t_reset;
    chk_cnt("R1 counter", 8'h00);
    chk_ctrl("R1 control", 8'h00);
    chk("R1 wdt_rst", wdt_rst, 0);
  endtask

  task automatic t_keys;
    wr(1'b0, 16'h5A3C);
    chk_cnt("R2 keyed count load", 8'h3C);
    chk_ctrl("R5 control read while count loaded", 8'h00);
    wr(1'b0, 16'hA511);
    chk_cnt("R4 swapped key on counter", 8'h3C);
    wr(1'b0, 16'h5B22);
    chk_cnt("R4 near-miss key on counter", 8'h3C);
    wr(1'b0, 16'h5A77, 1'b0);
    chk_cnt("R4 byte-wide write on counter", 8'h3C);
    wr(1'b1, 16'h5AC1);
    chk_ctrl("R4 counter key on control", 8'h00);
    wr(1'b1, 16'hA5C1, 1'b0);
    chk_ctrl("R4 byte-wide write on control", 8'h00);
    wr(1'b1, 16'hA55A);
    chk_ctrl("R3 keyed control, bits 4:3 read 0", 8'h42);
    wr(1'b1, 16'hA500);
    chk_ctrl("R3 control cleared", 8'h00);
    wr(1'b0, 16'h5A00);
  endtask

  task automatic t_rate(input int code);
    int p = 32 << code;
    wr(1'b1, 16'hA580 | 16'(code));
    skip(p - 1);
    chk_cnt($sformatf("R6 code %0d before first step", code), 8'h00);
    skip(1);
    chk_cnt($sformatf("R6 code %0d first step", code), 8'h01);
    skip(p);
    chk_cnt($sformatf("R6 code %0d second step", code), 8'h02);
    wr(1'b1, 16'hA500);
    skip(3 * p);
    chk_cnt("R6 disabled counter holds", 8'h02);
    wr(1'b0, 16'h5A00);
  endtask

  task automatic t_restart;
    wr(1'b1, 16'hA580);
    skip(20);
    wr(1'b1, 16'hA581);      // code change mid-period
    skip(63);
    chk_cnt("R7 code change restarts prescaler", 8'h00);
    skip(1);
    chk_cnt("R7 full period after code change", 8'h01);
    skip(30);
    wr(1'b1, 16'hA501);      // disable mid-period
    wr(1'b1, 16'hA581);
    skip(63);
    chk_cnt("R7 disable restarts prescaler", 8'h01);
    skip(1);
    chk_cnt("R7 full period after re-enable", 8'h02);
    wr(1'b1, 16'hA500);
    wr(1'b0, 16'h5A00);
  endtask

  task automatic t_wrap(input int code, input logic wd);
    int p = 32 << code;
    wr(1'b0, 16'h5AFF);
    wr(1'b1, 16'hA580 | (wd ? 16'h0040 : 16'h0) | 16'(code));
    skip(p - 1);
    chk("R9 no pulse before wrap", wdt_rst, 0);
    chk_cnt("R8 at 0xFF before wrap", 8'hFF);
    skip(1);
    chk_cnt("R8 counter wrapped to zero", 8'h00);
    chk_ctrl("R8 flag set on wrap", 8'hA0 | (wd ? 8'h40 : 8'h0) | 8'(code));
    chk(wd ? "R9 pulse starts at wrap" : "R9 no pulse in interval mode", wdt_rst, wd);
    skip(15);
    chk(wd ? "R9 pulse still high at 16th clock" : "R9 interval stays low", wdt_rst, wd);
    skip(1);
    chk("R9 pulse over after 16 clocks", wdt_rst, 0);
    wr(1'b1, 16'hA500 | 16'(code));
    chk_ctrl("R8 flag cleared by keyed 0", 8'(code));
  endtask

  task automatic t_flag_rules;
    wr(1'b0, 16'h5AFF);
    wr(1'b1, 16'hA580);
    skip(31);
    wr(1'b1, 16'hA580);      // clear attempt in the wrap cycle
    chk_ctrl("R8 wrap wins over clear", 8'hA0);
    wr(1'b1, 16'hA5A0);
    chk_ctrl("R8 writing 1 keeps flag", 8'hA0);
    wr(1'b1, 16'hA500);
    wr(1'b1, 16'hA520);
    chk_ctrl("R8 writing 1 never sets flag", 8'h00);
    wr(1'b0, 16'h5A10);
    chk_cnt("R2 counter reload", 8'h10);
  endtask

  initial begin
    bus_sel = 1'b0; bus_we = 1'b0; bus_wide = 1'b1; bus_wdata = '0;
    rst_n = 1'b0;
    skip(3);
    rst_n = 1'b1;
    skip(1);
    t_reset();
    t_keys();
    t_rate(0);
    t_rate(2);
    t_restart();
    t_wrap(0, 1'b1);
    t_wrap(7, 1'b1);
    t_wrap(3, 1'b0);
    t_flag_rules();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got cycle %0d expected end of run", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule